// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block holds the fault confinement state of a CAN protocol controller. The bit-level engine reports each detected protocol error as a one-cycle strobe carrying a 3-bit error kind. It also reports each frame that was sent or received without error. A level input tells the tracker whether the node was the transmitter when an error was found. From these inputs the block keeps a transmit error counter and a receive error counter, and derives the warning, passive and bus-off conditions from them.

Software sees two words. The error counter word holds both counters and a receive-passive flag. The protocol status word holds the three condition bits and a last-error code. Reading the status word marks the code as "no update". Three one-cycle event outputs fire when the node enters warning, passive or bus-off, so they can feed an interrupt register directly.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters are zero, the receive-passive flag and the three condition bits are clear, the last-error code reads 7 and no event output is high.
- R2: A strobe with a valid error kind (1 to 6) adds 8 to the transmit counter when `node_tx` is high, and adds 1 to the receive counter when `node_tx` is low. The result is visible one clock after the strobe.
- R3: `tx_done` subtracts 1 from the transmit counter and `rx_done` subtracts 1 from the receive counter. Neither counter goes below zero. In a cycle with a valid error strobe, both success pulses are ignored.
- R4: Status bit 6 (warning) is high while either counter is 96 or more. `warn_evt` is high for exactly the one cycle in which the bit first becomes set.
- R5: Status bit 5 (passive) is high while the transmit counter exceeds 127 or the receive-passive flag is set. `passive_evt` is high for one cycle when the bit becomes set.
- R6: A receive error that arrives while the receive counter is 127 leaves the counter at 127 and sets the receive-passive flag (error counter word bit 15). A later `rx_done` clears the flag and decrements the counter.
- R7: A transmit error that would carry the transmit counter past 255 sets status bit 7 (bus-off), holds the counter at 255 and pulses `busoff_evt` for one cycle. While bus-off is set, error strobes and success pulses leave the counters and flags unchanged, and bus-off stays set until reset.
- R8: A valid error strobe writes its kind into status bits 2:0 (1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC). A strobe that carries kind 0 or 7 has no effect on any output.
- R9: A `stat_rd` pulse sets the last-error code to 7 one clock later. If a valid error strobe arrives in the same cycle, the new kind is stored instead.
- R10: The error counter word has the transmit counter in bits 7:0, the receive counter in bits 14:8 and the receive-passive flag in bit 15. Status bits 4:3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse | input | 1 | One-cycle strobe marking a detected protocol error |
| err_code | input | 3 | Error kind that goes with `err_pulse` |
| node_tx | input | 1 | High while the node is the transmitter |
| tx_done | input | 1 | One-cycle pulse for a frame sent without error |
| rx_done | input | 1 | One-cycle pulse for a frame received without error |
| stat_rd | input | 1 | Pulse marking a software read of the status word |
| err_cnt_word | output | 16 | Receive-passive flag, receive counter and transmit counter |
| proto_stat | output | 8 | Bus-off, warning and passive bits, plus the last-error code |
| warn_evt | output | 1 | One-cycle pulse on entry into warning |
| passive_evt | output | 1 | One-cycle pulse on entry into passive |
| busoff_evt | output | 1 | One-cycle pulse on entry into bus-off |

## Verification
The counters are driven in four ways:
- Single receive and transmit errors confirm the step sizes.
- Success pulses on a zero counter confirm the floor at zero.
- A long run of receive errors climbs through 96 and 127 to the saturating overflow, which separates the warning threshold, the receive-passive flag and its clearing by a good reception.
- After a reset, a run of transmit errors climbs through 96, 128 and then past 255. This separates transmit-passive from bus-off and shows that later inputs are frozen out.

Collisions in a single cycle show which input wins: an error against a success pulse, and an error against a status read. Strobes that carry kinds 0 and 7 show that they are ignored.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [2:0] {
      LEC_CLEAN   = 3'd0,
      LEC_STUFF   = 3'd1,
      LEC_FORM    = 3'd2,
      LEC_NOACK   = 3'd3,
      LEC_RECESS  = 3'd4,
      LEC_DOMIN   = 3'd5,
      LEC_CRC     = 3'd6,
      LEC_NOUPD   = 3'd7
   } lec_t;

   // protocol status word bit positions
   localparam int PS_BUSOFF  = 7;
   localparam int PS_WARN    = 6;
   localparam int PS_PASSIVE = 5;

   // event vector indices
   localparam int EV_WARN    = 0;
   localparam int EV_PASSIVE = 1;
   localparam int EV_BUSOFF  = 2;
   localparam int EV_N       = 3;

   function automatic logic lec_is_error(input logic [2:0] c);
      return (c != LEC_CLEAN) && (c != LEC_NOUPD);
   endfunction

endpackage

// File: rtl/fc_counter.sv
module fc_counter #(
   parameter int W      = 8,
   parameter int INC    = 8,
   parameter bit STICKY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   input  logic         frz,
   output logic [W-1:0] cnt,
   output logic         over
);
   localparam int MAXV = (1 << W) - 1;

   if (W < 2 || W > 16) begin : g_bad_w
      $error("fc_counter: W out of range");
   end
   if (INC < 1 || INC > MAXV) begin : g_bad_inc
      $error("fc_counter: INC out of range");
   end

   logic [W:0] sum;
   logic       wrap;

   assign sum  = {1'b0, cnt} + (W+1)'(INC);
   assign wrap = sum > (W+1)'(MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!frz) begin
         if (inc) begin
            cnt <= wrap ? W'(MAXV) : sum[W-1:0];
         end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   if (STICKY) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     over <= 1'b0;
         else if (!frz && inc && wrap)   over <= 1'b1;
      end
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     over <= 1'b0;
         else if (!frz && inc && wrap)   over <= 1'b1;
         else if (!frz && !inc && dec)   over <= 1'b0;
      end
   end

   // R7
   frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frz |=> $stable(cnt));
   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !frz && cnt == '0) |=> cnt == '0);
   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !frz && int'(cnt) <= MAXV - INC)
      |=> {1'b0, cnt} == {1'b0, $past(cnt)} + (W+1)'(INC));

endmodule

// File: rtl/fc_status.sv
module fc_status
   import can_fc_pkg::*;
#(
   parameter int TW       = 8,
   parameter int RW       = 7,
   parameter int WARN_LIM = 96,
   parameter int TXP_LIM  = 127
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tec,
   input  logic [RW-1:0] rec,
   input  logic          rx_pass,
   input  logic          bus_off,
   output logic          warn,
   output logic          passive,
   output logic [EV_N-1:0] evt
);
   if (WARN_LIM >= (1 << TW) || WARN_LIM >= (1 << RW)) begin : g_bad_warn
      $error("fc_status: WARN_LIM does not fit a counter");
   end
   if (TXP_LIM >= (1 << TW) - 1) begin : g_bad_txp
      $error("fc_status: TXP_LIM does not fit the transmit counter");
   end

   logic [EV_N-1:0] cond, cond_q;

   assign warn    = (int'(tec) >= WARN_LIM) || (int'(rec) >= WARN_LIM);
   assign passive = (int'(tec) > TXP_LIM) || rx_pass;

   assign cond[EV_WARN]    = warn;
   assign cond[EV_PASSIVE] = passive;
   assign cond[EV_BUSOFF]  = bus_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond;
   end

   for (genvar i = 0; i < EV_N; i++) begin : g_edge
      assign evt[i] = cond[i] & ~cond_q[i];
   end

   // R7
   busoff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off |=> bus_off);
   // R4
   warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[EV_WARN] |=> !evt[EV_WARN]);
   // R5
   passive_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[EV_PASSIVE] |=> !evt[EV_PASSIVE]);

endmodule

// File: rtl/fc_lastcode.sv
module fc_lastcode
   import can_fc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic [2:0] code,
   input  logic       rd,
   output lec_t       lec
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lec <= LEC_NOUPD;
      else if (hit) lec <= lec_t'(code);
      else if (rd)  lec <= LEC_NOUPD;
   end

   // R9
   lec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !hit) |=> lec == LEC_NOUPD);
   // R8
   lec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !rd) |=> $stable(lec));

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
   import can_fc_pkg::*;
#(
   parameter int TEC_W    = 8,
   parameter int REC_W    = 7,
   parameter int TX_STEP  = 8,
   parameter int RX_STEP  = 1,
   parameter int WARN_LIM = 96,
   parameter int TXP_LIM  = 127
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        err_pulse,
   input  logic [2:0]  err_code,
   input  logic        node_tx,
   input  logic        tx_done,
   input  logic        rx_done,
   input  logic        stat_rd,
   output logic [15:0] err_cnt_word,
   output logic [7:0]  proto_stat,
   output logic        warn_evt,
   output logic        passive_evt,
   output logic        busoff_evt
);
   localparam int WORD_W = 16;

   if (TEC_W + REC_W + 1 != WORD_W) begin : g_bad_layout
      $error("can_fault_tracker: counters must fill the 16-bit word");
   end

   logic             hit;
   logic [TEC_W-1:0] tec;
   logic [REC_W-1:0] rec;
   logic             bo, rp, warn, passive;
   logic [EV_N-1:0]  evt;
   lec_t             lec;

   assign hit = err_pulse && lec_is_error(err_code);

   fc_counter #(.W(TEC_W), .INC(TX_STEP), .STICKY(1'b1)) u_tec (
      .clk (clk), .rst_n (rst_n),
      .inc (hit & node_tx),
      .dec (tx_done & ~hit),
      .frz (bo),
      .cnt (tec), .over (bo)
   );

   fc_counter #(.W(REC_W), .INC(RX_STEP), .STICKY(1'b0)) u_rec (
      .clk (clk), .rst_n (rst_n),
      .inc (hit & ~node_tx),
      .dec (rx_done & ~hit),
      .frz (bo),
      .cnt (rec), .over (rp)
   );

   fc_status #(.TW(TEC_W), .RW(REC_W), .WARN_LIM(WARN_LIM), .TXP_LIM(TXP_LIM)) u_stat (
      .clk (clk), .rst_n (rst_n),
      .tec (tec), .rec (rec), .rx_pass (rp), .bus_off (bo),
      .warn (warn), .passive (passive), .evt (evt)
   );

   fc_lastcode u_lec (
      .clk (clk), .rst_n (rst_n),
      .hit (hit), .code (err_code), .rd (stat_rd),
      .lec (lec)
   );

   assign err_cnt_word = {rp, rec, tec};
   assign proto_stat   = {bo, warn, passive, 2'b00, lec};
   assign warn_evt     = evt[EV_WARN];
   assign passive_evt  = evt[EV_PASSIVE];
   assign busoff_evt   = evt[EV_BUSOFF];

   // R8
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_pulse && !lec_is_error(err_code) && !tx_done && !rx_done && !stat_rd)
      |=> $stable(err_cnt_word) && $stable(proto_stat));
   // R6
   rx_pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rp) |-> rec == '1);

endmodule

// File: tb/sim_can_fault_tracker.sv
`timescale 1ns/1ps
module sim_can_fault_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_pulse = 1'b0;
   logic [2:0]  err_code = 3'd0;
   logic        node_tx = 1'b0;
   logic        tx_done = 1'b0;
   logic        rx_done = 1'b0;
   logic        stat_rd = 1'b0;
   logic [15:0] err_cnt_word;
   logic [7:0]  proto_stat;
   logic        warn_evt, passive_evt, busoff_evt;

   always #2 clk = ~clk;

   can_fault_tracker u0 (
      .clk (clk), .rst_n (rst_n),
      .err_pulse (err_pulse), .err_code (err_code), .node_tx (node_tx),
      .tx_done (tx_done), .rx_done (rx_done), .stat_rd (stat_rd),
      .err_cnt_word (err_cnt_word), .proto_stat (proto_stat),
      .warn_evt (warn_evt), .passive_evt (passive_evt), .busoff_evt (busoff_evt)
   );

   typedef struct {
      logic [15:0] ec;
      logic [7:0]  ps;
      logic [2:0]  ev;
      string       tag;
   } exp_t;

   exp_t exq[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // reference model
   int m_tec, m_rec;
   bit m_rp, m_bo, m_pw, m_pp, m_pb;
   int m_lec;

   task automatic model_reset();
      m_tec = 0; m_rec = 0; m_rp = 0; m_bo = 0;
      m_pw = 0; m_pp = 0; m_pb = 0; m_lec = 7;
   endtask

   task automatic step(input bit e, input int code, input bit tx,
                       input bit txd, input bit rxd, input bit rd, input string tag);
      bit valid, w, p;
      exp_t x;
      @(negedge clk);
      err_pulse = e; err_code = 3'(code); node_tx = tx;
      tx_done = txd; rx_done = rxd; stat_rd = rd;
      valid = e && code >= 1 && code <= 6;
      if (!m_bo) begin
         if (valid) begin
            if (tx) begin
               if (m_tec + 8 > 255) begin m_tec = 255; m_bo = 1; end
               else m_tec = m_tec + 8;
            end else begin
               if (m_rec + 1 > 127) begin m_rec = 127; m_rp = 1; end
               else m_rec = m_rec + 1;
            end
         end else begin
            if (txd && m_tec > 0) m_tec = m_tec - 1;
            if (rxd) begin
               if (m_rec > 0) m_rec = m_rec - 1;
               m_rp = 0;
            end
         end
      end
      if (valid)   m_lec = code;
      else if (rd) m_lec = 7;
      w = (m_tec >= 96) || (m_rec >= 96);
      p = (m_tec > 127) || m_rp;
      x.ec  = {m_rp, 7'(m_rec), 8'(m_tec)};
      x.ps  = {m_bo, w, p, 2'b00, 3'(m_lec)};
      x.ev  = {m_bo & ~m_pb, p & ~m_pp, w & ~m_pw};
      x.tag = tag;
      m_pw = w; m_pp = p; m_pb = m_bo;
      exq.push_back(x);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      err_pulse = 0; tx_done = 0; rx_done = 0; stat_rd = 0; node_tx = 0;
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   // monitor: compare one item per cycle, 1 ns after the edge that produced it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exq.size() > 0) begin
            exp_t x;
            logic [2:0] ev;
            x  = exq.pop_front();
            ev = {busoff_evt, passive_evt, warn_evt};
            n_chk++;
            if (err_cnt_word !== x.ec || proto_stat !== x.ps || ev !== x.ev) begin
               n_bad++;
               $display("FAIL %s: cnt=%h stat=%h evt=%b expected cnt=%h stat=%h evt=%b",
                        x.tag, err_cnt_word, proto_stat, ev, x.ec, x.ps, x.ev);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state, checked directly
      n_chk++;
      if (err_cnt_word !== 16'h0000 || proto_stat !== 8'h07 ||
          {busoff_evt, passive_evt, warn_evt} !== 3'b000) begin
         n_bad++;
         $display("FAIL R1: cnt=%h stat=%h expected cnt=0000 stat=07", err_cnt_word, proto_stat);
      end
      rst_n = 1;
      idle("R1");

      // R2 / R8: receive error kind 1, transmit error kind 3
      step(1, 1, 0, 0, 0, 0, "R2 rx step");
      step(0, 0, 0, 0, 0, 1, "R9 read clears code");
      step(1, 3, 1, 0, 0, 0, "R2 tx step");
      step(1, 6, 1, 0, 0, 1, "R9 error beats read");
      // R8 ignored kinds
      step(1, 0, 1, 0, 0, 0, "R8 kind 0 ignored");
      step(1, 7, 0, 0, 0, 0, "R8 kind 7 ignored");
      // R3 error beats success
      step(1, 2, 0, 1, 1, 0, "R3 error beats success");
      // R3 decrement to floor
      for (int i = 0; i < 18; i++) step(0, 0, 0, 1, 1, 0, "R3 decrement floor");
      // R10 mixed layout
      step(1, 4, 1, 0, 0, 0, "R10 layout");
      step(1, 5, 0, 0, 0, 0, "R10 layout");

      // R4 R5 R6: receive counter to saturation
      for (int i = 0; i < 130; i++) step(1, 1 + (i % 6), 0, 0, 0, 0, "R4 R6 rx climb");
      step(0, 0, 0, 0, 1, 0, "R6 rx_done clears passive");
      step(0, 0, 0, 0, 1, 0, "R6 rx_done after clear");
      idle("R5 idle");

      // R5 R7: transmit counter to bus-off
      do_reset();
      idle("R1 after reset");
      for (int i = 0; i < 33; i++) step(1, 5, 1, 0, 0, 0, "R4 R5 R7 tx climb");
      step(1, 2, 0, 1, 1, 0, "R7 frozen rx error");
      step(0, 0, 0, 1, 1, 0, "R7 frozen success");
      step(0, 0, 0, 0, 0, 1, "R7 read in bus-off");
      idle("R7 hold");
      idle("R7 hold");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule